// File: doc/BRIEF.md
# Register-Operate Execute Unit

This block carries out the three register-to-register operate instructions of a small 16-bit load/store machine: addition, bitwise AND and bitwise inversion. It owns an eight-entry by 16-bit register file. Each cycle it can accept one decoded instruction word with a valid strobe. It reads the named sources combinationally, forms the result, and writes the destination register on the clock edge that accepts the instruction.

For addition and AND, a single mode bit picks the second operand. That operand is either a third register or a 5-bit immediate, sign-extended to 16 bits. Inversion uses only the first source, and that source may also be the destination.

One cycle after each accepted instruction, the block presents a one-cycle write strobe together with the destination index and the written value. Downstream logic uses these to update the negative/zero/positive flags. Any word whose opcode is not one of the three is accepted on the bus but causes no write.

Top module: `opx_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and drives `wr_en` low; afterwards every register reads back as 0x0000.
- R2: Opcode 4'b0001 in bits [15:12] with bit [5] = 0 writes src1 + src2 to the destination. The destination index is in [11:9], src1 in [8:6] and src2 in [2:0].
- R3: With bit [5] = 1, the second operand of ADD and AND is bits [4:0] sign-extended to 16 bits. Bit 4 set gives a negative value, down to -16.
- R4: Opcode 4'b0101 writes the bitwise AND of src1 and the second operand, in both register mode and immediate mode.
- R5: Opcode 4'b1001 writes the bitwise inverse of src1, and bits [5:0] are ignored. This holds when the destination and the source are the same register.
- R6: For each accepted legal instruction, `wr_en` is high for exactly the next cycle. In that cycle `wr_addr` equals the destination index and `wr_data` equals the value now held in that register.
- R7: While `instr_valid` is low, no register changes and `wr_en` stays low the following cycle.
- R8: A valid word with any opcode other than 0001, 0101 or 1001 changes no register and leaves `wr_en` low the following cycle.
- R9: A result written on one edge is read as a source by an instruction presented in the very next cycle.
- R10: Addition wraps modulo 2^16, and no carry or overflow is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Decoded instruction word |
| wr_en | output | 1 | One-cycle strobe: a register was written on the last edge |
| wr_addr | output | 3 | Index of the register written |
| wr_data | output | 16 | Value written, for flag update |

## Verification
The bench builds the unit with its default parameters: eight 16-bit registers and a 5-bit immediate. With these values, the extremes of the immediate (+15 and -16) and the wrap from 0xFFFF to 0x0000 can be reached in a handful of instructions. Every register index is visited, both by the post-reset read-back and as a write destination. Each register is read back through an add-immediate-zero instruction, so skipped writes and stray writes both show up at the write port.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 8;
    localparam int REG_AW  = $clog2(REG_CNT);
    localparam int IMM_W   = 5;
    localparam int OPC_W   = 4;
    localparam int INSN_W  = 16;

    // field positions inside the instruction word
    localparam int OPC_LSB  = INSN_W - OPC_W;
    localparam int DST_LSB  = 9;
    localparam int SRC1_LSB = 6;
    localparam int MODE_BIT = 5;
    localparam int SRC2_LSB = 0;
    localparam int IMM_LSB  = 0;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_AND  = 2'd2,
        OP_INV  = 2'd3
    } op_e;

    typedef struct packed {
        logic              legal;
        op_e               op;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src1;
        logic [REG_AW-1:0] src2;
        logic              imm_mode;
        logic [DATA_W-1:0] imm_ext;
    } dec_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc          = insn[OPC_LSB +: OPC_W];
        dec.dst      = insn[DST_LSB +: REG_AW];
        dec.src1     = insn[SRC1_LSB +: REG_AW];
        dec.src2     = insn[SRC2_LSB +: REG_AW];
        dec.imm_mode = insn[MODE_BIT];
        dec.imm_ext  = sext_imm(insn[IMM_LSB +: IMM_W]);
        unique case (opc)
            OPC_ADD: begin dec.op = OP_ADD;  dec.legal = 1'b1; end
            OPC_AND: begin dec.op = OP_AND;  dec.legal = 1'b1; end
            OPC_NOT: begin dec.op = OP_INV;  dec.legal = 1'b1; end
            default: begin dec.op = OP_NONE; dec.legal = 1'b0; end
        endcase
    end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
    parameter int NREG = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (we && wa == AW'(i))
                mem[i] <= wd;
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            OP_INV:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/opx_unit.sv
module opx_unit
    import opx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr_word,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    dec_t              dec;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] result;
    logic              do_write;

    opx_decode u_dec (
        .insn (instr_word),
        .dec  (dec)
    );

    opx_regfile #(.NREG(REG_CNT), .W(DATA_W)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (dec.src1),
        .ra_b (dec.src2),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we   (do_write),
        .wa   (dec.dst),
        .wd   (result)
    );

    assign opnd_b   = dec.imm_mode ? dec.imm_ext : rd_b;
    assign do_write = instr_valid && dec.legal;

    opx_alu u_alu (
        .op (dec.op),
        .a  (rd_a),
        .b  (opnd_b),
        .y  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_addr <= dec.dst;
                wr_data <= result;
            end
        end
    end
endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk
    import opx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [INSN_W-1:0] instr_word,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_a,
    input logic [DATA_W-1:0] rd_b
);
    logic [OPC_W-1:0] opc;
    logic             known;
    assign opc   = instr_word[OPC_LSB +: OPC_W];
    assign known = (opc == OPC_ADD) || (opc == OPC_AND) || (opc == OPC_NOT);

    // R7
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !wr_en);

    // R8
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !known) |=> !wr_en);

    // R6
    dst_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && known) |=> (wr_en && wr_addr == $past(instr_word[DST_LSB +: REG_AW])));

    // R5
    inv_result_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opc == OPC_NOT) |=> (wr_data == ~$past(rd_a)));

    // R10
    add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opc == OPC_ADD && !instr_word[MODE_BIT])
        |=> (wr_data == DATA_W'($past(rd_a) + $past(rd_b))));
endmodule

bind opx_unit opx_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_a        (rd_a),
    .rd_b        (rd_b)
);

// File: tb/opx_unit_tb_top.sv
module opx_unit_tb_top;

    // 20-unit period: 50 MHz with 1 ns units
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] model [8];
    logic [2:0]  q_addr [$];
    logic [15:0] q_data [$];
    string       q_tag  [$];
    string       quiet_tag = "";

    always #10 clk = ~clk;

    opx_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    function automatic logic [15:0] w_add_r(int d, int a, int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] w_add_i(int d, int a, int imm);
        return {4'b0001, 3'(d), 3'(a), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] w_and_r(int d, int a, int b);
        return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] w_and_i(int d, int a, int imm);
        return {4'b0101, 3'(d), 3'(a), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] w_not(int d, int a, logic [5:0] junk);
        return {4'b1001, 3'(d), 3'(a), junk};
    endfunction

    task automatic fail(string tag, logic [31:0] act, logic [31:0] exp);
        bad++;
        $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    // driver: presents one word and pushes the expected write
    task automatic issue(logic [15:0] w, bit v, string tag);
        logic [15:0] a, b, res;
        logic [2:0]  d;
        bit          wr;
        @(negedge clk);
        instr_word  = w;
        instr_valid = v;
        d  = w[11:9];
        a  = model[w[8:6]];
        b  = w[5] ? {{11{w[4]}}, w[4:0]} : model[w[2:0]];
        wr = v;
        case (w[15:12])
            4'b0001: res = a + b;
            4'b0101: res = a & b;
            4'b1001: res = ~a;
            default: begin res = 16'h0; wr = 1'b0; end
        endcase
        if (wr) begin
            model[d] = res;
            q_addr.push_back(d);
            q_data.push_back(res);
            q_tag.push_back(tag);
        end else begin
            quiet_tag = tag;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 8; i++) issue(w_add_i(i, i, 0), 1'b1, tag);
    endtask

    // monitor: compares the write port against the queue
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                if (wr_en) begin
                    if (q_addr.size() == 0) begin
                        total++;
                        fail("R7/R8 unexpected write", {16'h0, wr_data}, 32'h0);
                    end else begin
                        logic [2:0]  ea;
                        logic [15:0] ed;
                        string       et;
                        ea = q_addr.pop_front();
                        ed = q_data.pop_front();
                        et = q_tag.pop_front();
                        total++;
                        if (wr_addr !== ea || wr_data !== ed)
                            fail(et, {13'h0, wr_addr, wr_data}, {13'h0, ea, ed});
                    end
                end else begin
                    if (q_addr.size() != 0) begin
                        total++;
                        fail({q_tag[0], " R6 missing strobe"}, 32'h0, 32'h1);
                        void'(q_addr.pop_front());
                        void'(q_data.pop_front());
                        void'(q_tag.pop_front());
                    end else if (quiet_tag != "") begin
                        total++;
                        quiet_tag = "";
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        total++;
        if (wr_en !== 1'b0) fail("R1 strobe in reset", {31'h0, wr_en}, 32'h0);
        rst = 1'b0;

        read_all("R1 reset value");

        issue(w_add_i(1, 0, 5),   1'b1, "R3 add imm +5");
        issue(w_add_i(2, 0, -16), 1'b1, "R3 add imm -16");
        issue(w_add_i(3, 0, 15),  1'b1, "R3 add imm +15");
        issue(w_add_r(4, 1, 3),   1'b1, "R2 add reg");
        issue(w_add_r(4, 4, 4),   1'b1, "R9 back-to-back");
        issue(w_add_r(5, 2, 2),   1'b1, "R2 add negatives");
        issue(w_not(6, 0, 6'h2A), 1'b1, "R5 not ignores low bits");
        issue(w_add_i(7, 6, 1),   1'b1, "R10 wrap to zero");
        issue(w_add_r(7, 6, 6),   1'b1, "R10 wrap FFFF+FFFF");
        issue(w_and_r(5, 2, 3),   1'b1, "R4 and reg");
        issue(w_and_i(1, 6, -2),  1'b1, "R4 and imm negative");
        issue(w_and_i(3, 4, 7),   1'b1, "R4 and imm positive");
        issue(w_not(4, 4, 6'h3F), 1'b1, "R5 not same register");
        issue(w_not(4, 4, 6'h00), 1'b1, "R5 not twice");

        issue(w_add_i(1, 1, 9), 1'b0, "R7 valid low");
        idle();
        issue(w_add_i(1, 1, 0), 1'b1, "R7 register unchanged");
        issue({4'b0000, 12'h3FF}, 1'b1, "R8 opcode 0000");
        issue({4'b1111, 12'h27F}, 1'b1, "R8 opcode 1111");
        issue({4'b0011, 12'h241}, 1'b1, "R8 opcode 0011");
        issue(w_add_i(1, 1, 0), 1'b1, "R8 register unchanged");
        read_all("R6 full readback");

        do_reset();
        read_all("R1 mid-run reset");
        idle();
        repeat (3) @(negedge clk);
        total++;
        if (q_addr.size() != 0) fail("R6 pending writes", q_addr.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule